// File: doc/BRIEF.md
# Frame Ring Sample Memory Controller

This controller runs a single-port sample SRAM as a ring of four frames behind a digitizer that never stops. Pairs of 16-bit samples are packed into one 32-bit word and written into the frame that is currently open. The memory port alternates between a write slot and a read slot on successive cycles. Writing therefore never waits, and earlier frames are read back in the gaps.

A frame-sync pulse closes the open frame and opens the next one in the ring. Every closed frame is streamed out on the continuous path. A frame that a trigger has marked is also streamed on the triggered path. Each readout starts with a header word that gives the frame number and the word count, and the stored words follow. The SRAM sits outside the block and returns read data one cycle after the address.

Top module: `frame_ring_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no output stream is valid, `mem_we` is low and `overrun` is low.
- R2: The first cycle after reset is a write slot. Write slots and read slots then alternate, and `mem_we` rises only in a write slot.
- R3: A sample pair accepted with `s_valid` is written as `{samp_b, samp_a}` in the first write slot that follows its acceptance.
- R4: A frame holds at most `frame_len` words. A sample pair that arrives while the open frame is full is dropped, and `mem_we` stays low.
- R5: The write address is `{frame[1:0], offset}`. A `fsync` pulse moves to the next frame modulo 4 with offset zero. A word written in the same cycle as `fsync` still belongs to the closing frame.
- R6: A header word carries the frame number in bits [31:30] and the word count in the low bits, and all other bits are zero.
- R7: Every closed frame is read on the continuous path. The header comes first, then the words in address order. Each output beat is valid in the cycle after its read slot.
- R8: A trigger marks the open frame and the frame opened by the next `fsync`. If the trigger arrives in the same cycle as `fsync`, it marks the closing frame and the new one. Marked frames are also read on the triggered path.
- R9: When a new readout is chosen, a waiting triggered readout wins over a continuous one. Within one path the oldest closed frame goes first. A readout that has started is never preempted.
- R10: If `fsync` opens a frame that still waits for readout or is being read, `overrun` is set and stays set. The pending readouts of that frame are discarded and an active readout of it stops.
- R11: A frame closed with no words is read out as a header alone, with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_len | input | OFS_W+1 | Maximum number of words in a frame |
| s_valid | input | 1 | Sample pair present |
| samp_a | input | SW | Earlier sample of the pair |
| samp_b | input | SW | Later sample of the pair |
| fsync | input | 1 | Close the open frame and open the next |
| trig | input | 1 | Mark the open frame and the next frame |
| mem_addr | output | OFS_W+2 | SRAM address |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 2*SW | SRAM write data |
| mem_rdata | input | 2*SW | SRAM read data, one cycle after the address |
| nu_valid | output | 1 | Triggered path beat valid |
| nu_hdr | output | 1 | Current beat is a header |
| nu_data | output | 2*SW | Triggered path beat |
| sn_valid | output | 1 | Continuous path beat valid |
| sn_hdr | output | 1 | Current beat is a header |
| sn_data | output | 2*SW | Continuous path beat |
| overrun | output | 1 | Sticky ring overrun flag |

## Verification
A pair accepted in cycle t reaches `mem_we` in cycle t+1 or t+2, whichever is the write slot. The write address and data are combinational and are compared 1 ns after the inputs are driven. Header and data beats appear in the cycle after the read slot that produced them. A close or an overrun takes effect one cycle after `fsync`. The bench model advances once per cycle in the same order and compares every registered output at the falling edge.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int NFRM = 4;
  typedef logic [1:0] frm_t;
  typedef struct packed {
    logic found;
    frm_t idx;
  } pick_t;

  function automatic frm_t frm_next(frm_t f);
    return f + 2'd1;
  endfunction

  // oldest set bit walking forward from the frame after the open one
  function automatic pick_t frm_oldest(logic [NFRM-1:0] m, frm_t wf);
    pick_t r;
    r = '0;
    for (int k = NFRM - 1; k >= 1; k--) begin
      frm_t i;
      i = wf + frm_t'(k);
      if (m[i]) begin
        r.found = 1'b1;
        r.idx   = i;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/frm_wr.sv
module frm_wr import frm_pkg::*; #(
  parameter int SW    = 16,
  parameter int OFS_W = 10,
  localparam int CW   = OFS_W + 1,
  localparam int DW   = 2 * SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     frame_len,
  input  logic              s_valid,
  input  logic [SW-1:0]     samp_a,
  input  logic [SW-1:0]     samp_b,
  input  logic              fsync,
  input  logic              trig,
  output logic              wr_slot,
  output logic              wr_fire,
  output logic [OFS_W+1:0]  wr_addr,
  output logic [DW-1:0]     wr_data,
  output frm_t              cur_frame,
  output logic [CW-1:0]     close_cnt,
  output logic              close_mark
);
  logic          slot_q, pend_v, cur_mark, carry;
  logic [DW-1:0] pend_d;
  logic [CW-1:0] wr_ofs;

  assign wr_slot    = ~slot_q;
  assign wr_fire    = wr_slot & pend_v & (wr_ofs < frame_len);
  assign wr_addr    = {cur_frame, wr_ofs[OFS_W-1:0]};
  assign wr_data    = pend_d;
  assign close_cnt  = wr_ofs + CW'(wr_fire);
  assign close_mark = cur_mark | trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= 1'b0;
      pend_v    <= 1'b0;
      pend_d    <= '0;
      wr_ofs    <= '0;
      cur_frame <= '0;
      cur_mark  <= 1'b0;
      carry     <= 1'b0;
    end else begin
      slot_q <= ~slot_q;
      if (s_valid) begin
        pend_v <= 1'b1;
        pend_d <= {samp_b, samp_a};
      end else if (wr_slot) begin
        pend_v <= 1'b0;
      end
      if (fsync) begin
        cur_frame <= frm_next(cur_frame);
        wr_ofs    <= '0;
        cur_mark  <= carry | trig;
        carry     <= 1'b0;
      end else begin
        wr_ofs <= wr_ofs + CW'(wr_fire);
        if (trig) begin
          cur_mark <= 1'b1;
          carry    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frm_rd.sv
module frm_rd import frm_pkg::*; #(
  parameter int OFS_W = 10,
  parameter int DW    = 32,
  localparam int CW   = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_slot,
  input  logic              close,
  input  frm_t              cur_frame,
  input  logic [CW-1:0]     close_cnt,
  input  logic              close_mark,
  output logic [OFS_W+1:0]  rd_addr,
  output logic              out_v,
  output logic              out_nu,
  output logic              out_hdr,
  output logic [DW-1:0]     hdr_q,
  output logic              overrun
);
  logic [CW-1:0]   cnt_q [NFRM];
  logic [NFRM-1:0] nu_p, sn_p;
  logic            busy, path;
  frm_t            rfrm, nf;
  logic [CW-1:0]   ridx;
  pick_t           pn, ps, sel;
  logic            sel_nu, start, issue, nf_busy, in_use, abort_rd;

  function automatic logic [DW-1:0] mk_hdr(frm_t f, logic [CW-1:0] c);
    return {f, (DW-2)'(c)};
  endfunction

  assign nf       = frm_next(cur_frame);
  assign pn       = frm_oldest(nu_p, cur_frame);
  assign ps       = frm_oldest(sn_p, cur_frame);
  assign sel_nu   = pn.found;
  assign sel      = sel_nu ? pn : ps;
  assign start    = rd_slot & ~busy & sel.found;
  assign issue    = rd_slot & busy;
  assign nf_busy  = busy && (rfrm == nf);
  assign in_use   = sn_p[nf] | nu_p[nf] | nf_busy;
  assign abort_rd = close & (nf_busy | (start & (sel.idx == nf)));
  assign rd_addr  = {rfrm, ridx[OFS_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFRM; i++) cnt_q[i] <= '0;
      nu_p    <= '0;
      sn_p    <= '0;
      busy    <= 1'b0;
      path    <= 1'b0;
      rfrm    <= '0;
      ridx    <= '0;
      out_v   <= 1'b0;
      out_nu  <= 1'b0;
      out_hdr <= 1'b0;
      hdr_q   <= '0;
      overrun <= 1'b0;
    end else begin
      out_v   <= issue | start;
      out_hdr <= start;
      if (start) begin
        out_nu <= sel_nu;
        path   <= sel_nu;
        hdr_q  <= mk_hdr(sel.idx, cnt_q[sel.idx]);
        rfrm   <= sel.idx;
        ridx   <= '0;
        busy   <= (cnt_q[sel.idx] != '0);
        if (sel_nu) nu_p[sel.idx] <= 1'b0;
        else        sn_p[sel.idx] <= 1'b0;
      end
      if (issue) begin
        out_nu <= path;
        ridx   <= ridx + CW'(1);
        if (ridx + CW'(1) == cnt_q[rfrm]) busy <= 1'b0;
      end
      if (close) begin
        cnt_q[cur_frame] <= close_cnt;
        sn_p[cur_frame]  <= 1'b1;
        nu_p[cur_frame]  <= close_mark;
        if (in_use) begin
          overrun  <= 1'b1;
          sn_p[nf] <= 1'b0;
          nu_p[nf] <= 1'b0;
        end
        if (abort_rd) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl import frm_pkg::*; #(
  parameter int SW    = 16,
  parameter int OFS_W = 10,
  localparam int CW   = OFS_W + 1,
  localparam int DW   = 2 * SW,
  localparam int AW   = OFS_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  frame_len,
  input  logic           s_valid,
  input  logic [SW-1:0]  samp_a,
  input  logic [SW-1:0]  samp_b,
  input  logic           fsync,
  input  logic           trig,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           nu_valid,
  output logic           nu_hdr,
  output logic [DW-1:0]  nu_data,
  output logic           sn_valid,
  output logic           sn_hdr,
  output logic [DW-1:0]  sn_data,
  output logic           overrun
);
  logic          wr_slot, wr_fire, close_mark, out_v, out_nu, out_hdr;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] close_cnt;
  logic [DW-1:0] hdr_q, beat;
  frm_t          cur_frame;

  frm_wr #(.SW(SW), .OFS_W(OFS_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .s_valid(s_valid),
    .samp_a(samp_a), .samp_b(samp_b), .fsync(fsync), .trig(trig),
    .wr_slot(wr_slot), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(mem_wdata),
    .cur_frame(cur_frame), .close_cnt(close_cnt), .close_mark(close_mark)
  );

  frm_rd #(.OFS_W(OFS_W), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_slot(~wr_slot), .close(fsync),
    .cur_frame(cur_frame), .close_cnt(close_cnt), .close_mark(close_mark),
    .rd_addr(rd_addr), .out_v(out_v), .out_nu(out_nu), .out_hdr(out_hdr),
    .hdr_q(hdr_q), .overrun(overrun)
  );

  assign mem_addr = wr_slot ? wr_addr : rd_addr;
  assign mem_we   = wr_fire;
  assign beat     = out_hdr ? hdr_q : mem_rdata;
  assign nu_valid = out_v & out_nu;
  assign sn_valid = out_v & ~out_nu;
  assign nu_hdr   = out_hdr;
  assign sn_hdr   = out_hdr;
  assign nu_data  = beat;
  assign sn_data  = beat;
endmodule

// File: rtl/frm_chk.sv
module frm_chk #(
  parameter int OFS_W = 10,
  localparam int CW   = OFS_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_slot,
  input logic             mem_we,
  input logic [OFS_W-1:0] ofs,
  input logic [CW-1:0]    frame_len,
  input logic             nu_valid,
  input logic             sn_valid,
  input logic             overrun
);
  // R2
  we_in_write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_slot);
  // R4
  we_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, ofs} < frame_len));
  // R7
  beat_after_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nu_valid || sn_valid) |-> wr_slot);
  // R9
  single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nu_valid && sn_valid));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind frame_ring_ctrl frm_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_slot(wr_slot), .mem_we(mem_we),
  .ofs(mem_addr[OFS_W-1:0]), .frame_len(frame_len),
  .nu_valid(nu_valid), .sn_valid(sn_valid), .overrun(overrun)
);

// File: tb/sim_frame_ring_ctrl.sv
module sim_frame_ring_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SW    = 16;
  localparam int OFS_W = 4;
  localparam int FR    = 1 << OFS_W;
  localparam int DW    = 2 * SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [OFS_W:0] frame_len = '0;
  logic s_valid = 1'b0, fsync = 1'b0, trig = 1'b0;
  logic [SW-1:0] samp_a = '0, samp_b = '0;
  logic [OFS_W+1:0] mem_addr;
  logic mem_we, nu_valid, nu_hdr, sn_valid, sn_hdr, overrun;
  logic [DW-1:0] mem_wdata, mem_rdata, nu_data, sn_data;
  logic [DW-1:0] sram [4*FR];

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) sram[mem_addr] <= mem_wdata;
    mem_rdata <= sram[mem_addr];
  end

  frame_ring_ctrl #(.SW(SW), .OFS_W(OFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .s_valid(s_valid),
    .samp_a(samp_a), .samp_b(samp_b), .fsync(fsync), .trig(trig),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .nu_valid(nu_valid), .nu_hdr(nu_hdr), .nu_data(nu_data),
    .sn_valid(sn_valid), .sn_hdr(sn_hdr), .sn_data(sn_data), .overrun(overrun)
  );

  // reference model state
  int m_slot, m_pv, m_wf, m_wo, m_mark, m_carry, m_busy, m_path, m_rf, m_ri, m_ovr;
  int m_cnt [4];
  int m_nu [4];
  int m_sn [4];
  int m_ov, m_oh, m_op;
  logic [DW-1:0] m_pd, m_oexp;
  logic [DW-1:0] exp_mem [4*FR];
  string m_otag;
  int r9_seen = 0, r11_seen = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  task automatic check_outputs();
    chk("R8", 64'(nu_valid), 64'(m_ov != 0 && m_op != 0));
    chk("R7", 64'(sn_valid), 64'(m_ov != 0 && m_op == 0));
    chk("R10", 64'(overrun), 64'(m_ovr));
    if (m_ov != 0) begin
      chk(m_otag, 64'(m_op != 0 ? nu_hdr : sn_hdr), 64'(m_oh));
      chk(m_otag, 64'(m_op != 0 ? nu_data : sn_data), 64'(m_oexp));
    end
  endtask

  task automatic model_step(input int flen);
    int sw, fire, nf, inuse, f, p;
    sw   = (m_slot == 0);
    fire = sw && m_pv != 0 && (m_wo < flen);
    // combinational memory port checks
    chk((sw && m_pv != 0 && !fire) ? "R4" : "R2", 64'(mem_we), 64'(fire));
    if (fire != 0) begin
      chk("R5", 64'(mem_addr), 64'(m_wf * FR + m_wo));
      chk("R3", 64'(mem_wdata), 64'(m_pd));
      exp_mem[m_wf * FR + m_wo] = m_pd;
    end
    if (!sw && m_busy != 0) chk("R7", 64'(mem_addr), 64'(m_rf * FR + m_ri));
    nf    = (m_wf + 1) % 4;
    inuse = (m_sn[nf] != 0) || (m_nu[nf] != 0) || (m_busy != 0 && m_rf == nf);
    m_ov  = 0;
    if (!sw) begin
      if (m_busy != 0) begin
        m_ov = 1; m_oh = 0; m_op = m_path;
        m_oexp = exp_mem[m_rf * FR + m_ri];
        m_otag = (m_path != 0) ? "R8" : "R7";
        m_ri++;
        if (m_ri == m_cnt[m_rf]) m_busy = 0;
      end else begin
        f = -1; p = 0;
        for (int k = 1; k < 4; k++)
          if (f < 0 && m_nu[(m_wf + k) % 4] != 0) begin f = (m_wf + k) % 4; p = 1; end
        for (int k = 1; k < 4; k++)
          if (f < 0 && m_sn[(m_wf + k) % 4] != 0) f = (m_wf + k) % 4;
        if (f >= 0) begin
          m_otag = "R6";
          if (m_cnt[f] == 0) begin m_otag = "R11"; r11_seen++; end
          if (p != 0 && (m_sn[0] + m_sn[1] + m_sn[2] + m_sn[3]) != 0) begin
            m_otag = "R9"; r9_seen++;
          end
          m_ov = 1; m_oh = 1; m_op = p;
          m_oexp = (DW'(f) << (DW - 2)) | DW'(m_cnt[f]);
          if (p != 0) m_nu[f] = 0; else m_sn[f] = 0;
          m_rf = f; m_ri = 0; m_path = p;
          m_busy = (m_cnt[f] != 0);
        end
      end
    end
    if (fsync) begin
      m_cnt[m_wf] = m_wo + fire;
      m_sn[m_wf]  = 1;
      m_nu[m_wf]  = (m_mark != 0 || trig);
      m_mark  = (m_carry != 0 || trig);
      m_carry = 0;
      if (inuse != 0) begin
        m_ovr = 1; m_sn[nf] = 0; m_nu[nf] = 0;
        if (m_busy != 0 && m_rf == nf) m_busy = 0;
      end
      m_wf = nf; m_wo = 0;
    end else begin
      if (trig) begin m_mark = 1; m_carry = 1; end
      m_wo += fire;
    end
    if (s_valid) begin m_pv = 1; m_pd = {samp_b, samp_a}; end
    else if (sw) m_pv = 0;
    m_slot ^= 1;
  endtask

  int n = 0;
  task automatic cyc(input bit sv, input bit fs, input bit tr);
    check_outputs();
    s_valid = sv; fsync = fs; trig = tr;
    samp_a = SW'(n * 3 + 7); samp_b = SW'(n * 5 + 1);
    #1;
    model_step(int'(frame_len));
    n++;
    @(negedge clk);
  endtask

  initial begin
    m_slot = 0; m_pv = 0; m_wf = 0; m_wo = 0; m_mark = 0; m_carry = 0;
    m_busy = 0; m_path = 0; m_rf = 0; m_ri = 0; m_ovr = 0; m_ov = 0; m_oh = 0; m_op = 0;
    m_pd = '0; m_oexp = '0; m_otag = "R1";
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_nu[i] = 0; m_sn[i] = 0; end
    frame_len = 6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", 64'(nu_valid), 0);
    chk("R1", 64'(sn_valid), 0);
    chk("R1", 64'(overrun), 0);
    chk("R1", 64'(mem_we), 0);
    rst_n = 1'b1;
    // A: normal flow with one trigger
    for (int i = 0; i < 96; i++) cyc(i % 4 == 1, i % 24 == 23, i == 30);
    // B: short frames, the surplus is dropped (R4)
    frame_len = 3;
    for (int i = 0; i < 60; i++) cyc(i % 2 == 0, i % 20 == 19, i == 5);
    // C: empty frames, trigger together with a sync (R11, R8)
    for (int i = 0; i < 40; i++) cyc(1'b0, i % 8 == 7, i == 15);
    // D: heavy traffic on both paths, forces overrun (R10, R9)
    frame_len = 15;
    for (int i = 0; i < 140; i++) cyc(i % 2 == 0, i % 10 == 9, i % 3 == 0);
    // E: drain
    for (int i = 0; i < 200; i++) cyc(1'b0, 1'b0, 1'b0);
    chk("R10", 64'(overrun), 1);
    chk("R9", 64'(r9_seen > 0), 1);
    chk("R11", 64'(r11_seen > 0), 1);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule